// File: doc/BRIEF.md
# AER Event Egress Queue

This block is the output stage of an address-event router. Routed events arrive from the ingress side as 8-bit words. Each word holds a 2-bit destination channel in bits [7:6] and a 6-bit destination address in bits [5:0]. Events wait in a small FIFO. They are sent one at a time to a downstream receiver over a 4-phase bundled-data request/acknowledge handshake. The receiver's acknowledge may arrive at any time relative to the local clock, so it passes through a synchroniser before the control logic uses it.

An event leaves the queue only after the receiver has acknowledged it. When the synchronised acknowledge is seen, the request drops and the FIFO head is popped on the same clock edge. The block then waits for the acknowledge to go low again before it offers the next event. The ingress side is given full, empty and occupancy status, plus a busy flag that is high while a handshake is in progress. A register keeps the payload of the last event that was acknowledged.

Top module: `aer_egress_queue`

## Requirements
- R1: After synchronous reset: `req_out`=0, `out_busy`=0, `fifo_empty`=1, `fifo_full`=0, `fifo_count`=0, `payload_out`=0 and `last_out`=0.
- R2: Events leave in the order they were pushed, unchanged, with the bit layout {channel[7:6], address[5:0]}. `fifo_count` tracks occupancy from 0 to 4. `fifo_full` is high exactly at 4 and `fifo_empty` exactly at 0.
- R3: A push while the FIFO holds 4 entries and no pop happens in that cycle is discarded: the count stays 4 and the word is never delivered.
- R4: A push and a pop on the same clock edge are both accepted, including when the FIFO is full. The count stays the same.
- R5: The acknowledge passes through two synchroniser flops. Take an acknowledge that rises before clock edge 1 and stays high. The request is still high after edges 1 and 2 and is low after edge 3.
- R6: With the FSM idle and the FIFO not empty, the next edge raises `req_out` and loads the FIFO head onto `payload_out`.
- R7: `payload_out` does not change while `req_out` stays high, even if pushes happen in that time.
- R8: In the drive state, a synchronised acknowledge of 1 drops `req_out` and pops the FIFO on the same edge.
- R9: After the pop, no new request is raised while the synchronised acknowledge is 1. The FSM returns to idle on the third edge after the acknowledge falls, and the next queued event is requested on the edge after that.
- R10: `last_out` takes the acknowledged payload on the edge that pops it, and holds it until the next acknowledgement.
- R11: `out_busy` is high exactly while the FSM is in drive or wait-release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Ingress writes `push_data` this cycle |
| push_data | input | 8 | Routed event {channel, address} |
| ack_in | input | 1 | Receiver acknowledge, asynchronous |
| req_out | output | 1 | Request to receiver |
| payload_out | output | 8 | Event being offered |
| last_out | output | 8 | Last acknowledged event |
| fifo_full | output | 1 | Occupancy equals depth |
| fifo_empty | output | 1 | Occupancy is zero |
| fifo_count | output | 3 | Occupancy, 0 to 4 |
| out_busy | output | 1 | Handshake in progress |

## Verification
The assertions assume the receiver follows the 4-phase protocol. It raises the acknowledge only while a request is high and keeps it high until the request has dropped. They also assume the ingress side pushes only when `fifo_full` is low, except in the deliberate overflow and same-edge tests. The stimulus changes `ack_in` and `push_valid` only on falling clock edges. Acknowledge is held for at least three rising edges in each phase, so the synchroniser sees every level. Pushes into a full FIFO are issued on purpose and only in the two tests where the discard and the same-edge push/pop are being checked.

// File: rtl/aer_egress_pkg.sv
package aer_egress_pkg;

  localparam int EG_DATA_W = 8;
  localparam int EG_DEPTH  = 4;

  typedef enum logic [1:0] {
    EG_IDLE  = 2'd0,
    EG_DRIVE = 2'd1,
    EG_WREL  = 2'd2
  } eg_state_t;

endpackage

// File: rtl/eg_level_sync.sv
module eg_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

  // The synchronised level can only rise after the raw input was high.
  AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(q_sync) |-> $past(chain[0])) else $error("sync rose without input"); // R5

endmodule

// File: rtl/eg_fifo.sv
module eg_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != FULL_CNT) || do_pop);

  // storage: no reset, single write port, suitable for RAM inference
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT) else $error("occupancy above depth"); // R2
  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == FULL_CNT)) else $error("overfill"); // R3
  AST_PUSH_POP_SAME: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(count)) else $error("push+pop changed count"); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("pop of empty fifo"); // R8

endmodule

// File: rtl/eg_handshake_fsm.sv
module eg_handshake_fsm
  import aer_egress_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_sync,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              q_pop,
  output logic              req,
  output logic [DATA_W-1:0] payload,
  output logic [DATA_W-1:0] last,
  output logic              busy
);

  eg_state_t state;

  assign q_pop = (state == EG_DRIVE) && ack_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= EG_IDLE;
      req     <= 1'b0;
      payload <= '0;
      last    <= '0;
      busy    <= 1'b0;
    end else begin
      unique case (state)
        EG_IDLE: begin
          if (!q_empty) begin
            state   <= EG_DRIVE;
            payload <= q_head;
            req     <= 1'b1;
            busy    <= 1'b1;
          end
        end
        EG_DRIVE: begin
          if (ack_sync) begin
            state <= EG_WREL;
            req   <= 1'b0;
            last  <= payload;
          end
        end
        EG_WREL: begin
          if (!ack_sync) begin
            state <= EG_IDLE;
            busy  <= 1'b0;
          end
        end
        default: begin
          state <= EG_IDLE;
          req   <= 1'b0;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req && !ack_sync) |=> $stable(payload)) else $error("payload moved under req"); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (req && ack_sync) |=> !req) else $error("req held after ack"); // R8
  AST_NO_REQ_WREL: assert property (@(posedge clk) disable iff (rst)
    (state == EG_WREL) |-> !req) else $error("req in wait-release"); // R9
  AST_LAST_ON_POP: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> (last == $past(payload))) else $error("last not captured"); // R10
  AST_BUSY_STATE: assert property (@(posedge clk) disable iff (rst)
    busy == (state != EG_IDLE)) else $error("busy mismatch"); // R11

endmodule

// File: rtl/aer_egress_queue.sv
module aer_egress_queue
  import aer_egress_pkg::*;
#(
  parameter int DATA_W      = EG_DATA_W,
  parameter int DEPTH       = EG_DEPTH,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              ack_in,
  output logic              req_out,
  output logic [DATA_W-1:0] payload_out,
  output logic [DATA_W-1:0] last_out,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              out_busy
);

  logic              ack_s;
  logic              pop;
  logic [DATA_W-1:0] head;

  eg_level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (ack_in),
    .q_sync  (ack_s)
  );

  eg_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push_valid),
    .wdata (push_data),
    .pop   (pop),
    .head  (head),
    .full  (fifo_full),
    .empty (fifo_empty),
    .count (fifo_count)
  );

  eg_handshake_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ack_sync (ack_s),
    .q_empty  (fifo_empty),
    .q_head   (head),
    .q_pop    (pop),
    .req      (req_out),
    .payload  (payload_out),
    .last     (last_out),
    .busy     (out_busy)
  );

  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(req_out) |-> $past(!fifo_empty)) else $error("req without data"); // R6

endmodule

// File: tb/tb_aer_egress_queue.sv
module tb_aer_egress_queue;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       ack_in = 1'b0;
  logic       req_out, fifo_full, fifo_empty, out_busy;
  logic [7:0] payload_out, last_out;
  logic [2:0] fifo_count;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  aer_egress_queue dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .ack_in(ack_in), .req_out(req_out), .payload_out(payload_out),
    .last_out(last_out), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count), .out_busy(out_busy)
  );

  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'h6A, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h55,
    8'hAA, 8'h1F, 8'hC0, 8'h7E, 8'h42, 8'h99};

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push_one(input logic [7:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50 && !req_out; i++) @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] exp, input int dly);
    wait_req();
    chk("R2 payload order", payload_out, exp);
    repeat (dly) @(negedge clk);
    chk("R7 payload held", payload_out, exp);
    ack_in = 1'b1;
    for (int i = 0; i < 20 && req_out; i++) @(negedge clk);
    chk("R10 last_out", last_out, exp);
    ack_in = 1'b0;
    for (int i = 0; i < 20 && out_busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", req_out, 0);
    chk("R1 busy", out_busy, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 count", fifo_count, 0);
    chk("R1 payload", payload_out, 0);
    chk("R1 last", last_out, 0);

    // vector table: groups of four, fill then drain
    for (int g = 0; g < NV; g += 4) begin
      for (int k = 0; k < 4; k++) begin
        push_one(VEC[g+k]);
        chk("R2 count fill", fifo_count, k+1);
      end
      chk("R2 full at 4", fifo_full, 1);
      for (int k = 0; k < 4; k++) recv(VEC[g+k], (g/4) + k);
      chk("R2 empty after drain", fifo_empty, 1);
      chk("R11 idle after drain", out_busy, 0);
    end

    // R6: request one edge after data present, R11 busy
    @(negedge clk); push_valid = 1'b1; push_data = 8'h11;
    @(negedge clk); push_valid = 1'b0;
    chk("R6 no req yet", req_out, 0);
    chk("R6 count", fifo_count, 1);
    @(negedge clk);
    chk("R6 req raised", req_out, 1);
    chk("R6 head loaded", payload_out, 8'h11);
    chk("R11 busy in drive", out_busy, 1);
    // R7: pushes during request leave payload untouched
    push_one(8'h22); push_one(8'h33); push_one(8'h44);
    chk("R7 payload stable", payload_out, 8'h11);
    chk("R2 full", fifo_full, 1);
    // R5 sync latency, R4 push+pop on full
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk);
    chk("R5 req after edge1", req_out, 1);
    @(negedge clk);
    chk("R5 req after edge2", req_out, 1);
    push_valid = 1'b1; push_data = 8'h55;
    @(negedge clk); push_valid = 1'b0;
    chk("R5 req low after edge3", req_out, 0);
    chk("R8 pop count", fifo_count, 4);
    chk("R4 full kept", fifo_full, 1);
    chk("R10 last", last_out, 8'h11);
    // R9 wait-release while ack high
    repeat (5) @(negedge clk);
    chk("R9 no req while ack", req_out, 0);
    chk("R11 busy in wrel", out_busy, 1);
    ack_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 still wrel", out_busy, 1);
    @(negedge clk);
    chk("R9 idle edge3", out_busy, 0);
    chk("R9 no req edge3", req_out, 0);
    @(negedge clk);
    chk("R9 next req edge4", req_out, 1);
    chk("R9 next payload", payload_out, 8'h22);
    recv(8'h22, 1); recv(8'h33, 0); recv(8'h44, 2); recv(8'h55, 0);
    chk("R4 drained", fifo_count, 0);

    // R3: push into full without pop discarded
    push_one(8'hA0); push_one(8'hA1); push_one(8'hA2); push_one(8'hA3);
    push_one(8'hEE);
    chk("R3 count stays", fifo_count, 4);
    recv(8'hA0, 0); recv(8'hA1, 0); recv(8'hA2, 0); recv(8'hA3, 0);
    repeat (10) @(negedge clk);
    chk("R3 no extra req", req_out, 0);
    chk("R3 empty", fifo_empty, 1);

    // R1 reset mid-handshake
    push_one(8'h5A);
    wait_req();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 req after rst", req_out, 0);
    chk("R1 count after rst", fifo_count, 0);
    chk("R1 last after rst", last_out, 0);
    chk("R1 busy after rst", out_busy, 0);

    summary();
  end

endmodule